// File: doc/BRIEF.md
# Octal-Byte Vector Multiply-Accumulate Unit

This block performs lane-parallel multiply-accumulate on 64-bit vectors, each made of eight signed bytes. It keeps an internal accumulator of eight signed 24-bit lanes. A multiply command multiplies each byte of the source vector `vs_i` by a per-lane second operand. That operand comes from the operand select field: one element of `vt_i` broadcast to every lane, the matching lane of `vt_i`, or the 5-bit immediate `cmd_imm_i`. The lane product then loads, accumulates into, subtracts from or negatively loads the accumulator lane.

Other commands copy one byte slice of every accumulator lane out as a 64-bit vector, or write vectors into the accumulator. Each command is presented for one cycle on `cmd_valid_i`. It retires at the next clock edge, with a one-cycle response strobe that carries read data and an error flag.

Top module: `vmac_unit`

## Requirements
- R1: After reset all accumulator lanes are zero and rsp_valid_o, rsp_err_o and rsp_data_o are zero.
- R2: A command accepted at a clock edge produces rsp_valid_o high for exactly the following cycle. rsp_valid_o is low after any cycle without a command. rsp_data_o is zero for every command that is not a read.
- R3: Lane i uses byte i of a vector, bits 8i+7:8i. The operand select cmd_sel_i picks the second operand as follows. Codes 0..7 broadcast signed byte cmd_sel_i of vt_i to all lanes. Code 5'h13 uses signed byte i of vt_i in lane i. Code 5'h1f uses cmd_imm_i, zero-extended, as an unsigned value for every lane. Source bytes of vs_i are signed.
- R4: Multiply op codes: 4'h0 adds the product to the lane, 4'h1 subtracts it, 4'h2 replaces the lane with the product, and 4'h3 replaces the lane with the negated product. All lane arithmetic wraps modulo 2^24.
- R5: A multiply command whose select code is not one of 0..7, 5'h13 or 5'h1f raises rsp_err_o together with rsp_valid_o and leaves every accumulator lane unchanged.
- R6: Read op codes 4'h6, 4'h5 and 4'h4 return lane bits 23:16, 15:8 and 7:0 respectively in byte i of rsp_data_o. Reads leave the accumulator unchanged, ignore the select code and never raise rsp_err_o.
- R7: Op code 4'h9 (write-high) sets lane bits 23:16 to byte i of vs_i and keeps bits 15:0.
- R8: Op code 4'h8 (write-low) sets lane bits 23:8 to the sign extension of byte i of vs_i and bits 7:0 to byte i of vt_i.
- R9: Op codes 4'h7 and 4'hA..4'hF are undefined. They raise rsp_err_o with rsp_valid_o and leave the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 4 | Operation code |
| cmd_sel_i | input | 5 | Second-operand select code |
| cmd_imm_i | input | 5 | Immediate operand, unsigned |
| vs_i | input | 64 | Source vector, eight signed bytes |
| vt_i | input | 64 | Second vector |
| rsp_valid_o | output | 1 | Command retired, one-cycle strobe |
| rsp_data_o | output | 64 | Read result vector |
| rsp_err_o | output | 1 | Illegal select or undefined op |

## Verification
Every response (rsp_valid_o, rsp_err_o, rsp_data_o) is registered and is due exactly one clock edge after the edge that accepts the command. An accumulator update made by a command is visible to a read command issued in the very next cycle. The bench drives each command at a falling edge, samples the response at the next falling edge, and only then updates its own lane model. A read therefore always compares against the state left by all earlier commands. Effects that cannot be seen on the response of the command itself, such as unchanged lanes after errors and the wrap on overflow, are confirmed by reading all three slices afterwards.

// File: rtl/vmac_pkg.sv
package vmac_pkg;
  typedef enum logic [3:0] {
    OP_MAC = 4'h0,
    OP_MSB = 4'h1,
    OP_MLD = 4'h2,
    OP_MNL = 4'h3,
    OP_RDL = 4'h4,
    OP_RDM = 4'h5,
    OP_RDH = 4'h6,
    OP_WRL = 4'h8,
    OP_WRH = 4'h9
  } vmac_op_e;

  localparam logic [4:0] SEL_FULL = 5'h13;
  localparam logic [4:0] SEL_IMM  = 5'h1f;
endpackage

// File: rtl/vmac_operand_sel.sv
module vmac_operand_sel #(
  parameter int unsigned LANES = 8,
  parameter int unsigned EW    = 8,
  parameter int unsigned SW    = 5,
  localparam int unsigned OW   = EW + 1,
  localparam int unsigned IW   = $clog2(LANES)
) (
  input  logic [SW-1:0]                 sel_i,
  input  logic [SW-1:0]                 imm_i,
  input  logic [LANES*EW-1:0]           vt_i,
  output logic [LANES-1:0][OW-1:0]      opnd_o,
  output logic                          illegal_o
);
  import vmac_pkg::*;

  logic          is_bcast, is_full, is_imm;
  logic [EW-1:0] bcast;

  assign is_bcast  = sel_i < SW'(LANES);
  assign is_full   = sel_i == SEL_FULL;
  assign is_imm    = sel_i == SEL_IMM;
  assign illegal_o = !(is_bcast || is_full || is_imm);
  assign bcast     = vt_i[sel_i[IW-1:0]*EW +: EW];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      if (is_imm)       opnd_o[g] = OW'(imm_i);
      else if (is_full) opnd_o[g] = {vt_i[g*EW+EW-1], vt_i[g*EW +: EW]};
      else              opnd_o[g] = {bcast[EW-1], bcast};
    end
  end
endmodule

// File: rtl/vmac_lane.sv
module vmac_lane #(
  parameter int unsigned EW  = 8,
  parameter int unsigned AW  = 24,
  localparam int unsigned OW = EW + 1,
  localparam int unsigned PW = EW + OW
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  vmac_pkg::vmac_op_e    op_i,
  input  logic [EW-1:0]         src_i,
  input  logic signed [OW-1:0]  opnd_i,
  input  logic [EW-1:0]         aux_i,
  output logic [AW-1:0]         acc_o,
  output logic [EW-1:0]         rd_o
);
  import vmac_pkg::*;

  logic [AW-1:0]        acc_q, acc_d;
  logic signed [PW-1:0] prod;
  logic [AW-1:0]        prod_ext;

  assign prod     = $signed(src_i) * opnd_i;
  assign prod_ext = {{(AW-PW){prod[PW-1]}}, prod};

  always_comb begin
    acc_d = acc_q;
    unique case (op_i)
      OP_MAC:  acc_d = acc_q + prod_ext;
      OP_MSB:  acc_d = acc_q - prod_ext;
      OP_MLD:  acc_d = prod_ext;
      OP_MNL:  acc_d = '0 - prod_ext;
      OP_WRH:  acc_d = {src_i, acc_q[AW-EW-1:0]};
      OP_WRL:  acc_d = {{(AW-2*EW){src_i[EW-1]}}, src_i, aux_i};
      default: acc_d = acc_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= acc_d;
  end

  always_comb begin
    unique case (op_i)
      OP_RDH:  rd_o = acc_q[AW-1 -: EW];
      OP_RDM:  rd_o = acc_q[2*EW-1:EW];
      default: rd_o = acc_q[EW-1:0];
    endcase
  end

  assign acc_o = acc_q;

  a_r5_idle_keeps_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(acc_q));
  a_r6_read_keeps_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && (op_i inside {OP_RDL, OP_RDM, OP_RDH}) |=> $stable(acc_q));
  a_r7_wrh_keeps_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && op_i == OP_WRH |=> acc_q[AW-EW-1:0] == $past(acc_q[AW-EW-1:0]));
  a_r4_load_ignores_old: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && op_i == OP_MLD && src_i == '0 |=> acc_q == '0);
endmodule

// File: rtl/vmac_unit.sv
module vmac_unit #(
  parameter int unsigned LANES = 8,
  parameter int unsigned EW    = 8,
  parameter int unsigned AW    = 24,
  parameter int unsigned SW    = 5,
  localparam int unsigned VW   = LANES * EW,
  localparam int unsigned OW   = EW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [3:0]    cmd_op_i,
  input  logic [SW-1:0] cmd_sel_i,
  input  logic [SW-1:0] cmd_imm_i,
  input  logic [VW-1:0] vs_i,
  input  logic [VW-1:0] vt_i,
  output logic          rsp_valid_o,
  output logic [VW-1:0] rsp_data_o,
  output logic          rsp_err_o
);
  import vmac_pkg::*;

  vmac_op_e                op;
  logic                    is_mul, is_read, is_write, sel_bad, cmd_bad, lane_en;
  logic [LANES-1:0][OW-1:0] opnd;
  logic [VW-1:0]           rd_bus;
  logic                    rsp_valid_q, rsp_err_q;
  logic [VW-1:0]           rsp_data_q;

  assign op       = vmac_op_e'(cmd_op_i);
  assign is_mul   = op inside {OP_MAC, OP_MSB, OP_MLD, OP_MNL};
  assign is_read  = op inside {OP_RDL, OP_RDM, OP_RDH};
  assign is_write = op inside {OP_WRL, OP_WRH};
  assign cmd_bad  = !(is_mul || is_read || is_write) || (is_mul && sel_bad);
  assign lane_en  = cmd_valid_i && !cmd_bad;

  vmac_operand_sel #(.LANES(LANES), .EW(EW), .SW(SW)) u_sel (
    .sel_i     (cmd_sel_i),
    .imm_i     (cmd_imm_i),
    .vt_i      (vt_i),
    .opnd_o    (opnd),
    .illegal_o (sel_bad)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [AW-1:0] acc_unused;
    vmac_lane #(.EW(EW), .AW(AW)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (lane_en),
      .op_i   (op),
      .src_i  (vs_i[g*EW +: EW]),
      .opnd_i (opnd[g]),
      .aux_i  (vt_i[g*EW +: EW]),
      .acc_o  (acc_unused),
      .rd_o   (rd_bus[g*EW +: EW])
    );
    a_r1_lane_reset_zero: assert property (@(posedge clk_i)
      !rst_ni |=> acc_unused == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= cmd_valid_i;
      rsp_err_q   <= cmd_valid_i && cmd_bad;
      rsp_data_q  <= (cmd_valid_i && is_read) ? rd_bus : '0;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_err_o   = rsp_err_q;
  assign rsp_data_o  = rsp_data_q;

  a_r2_valid_follows_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> rsp_valid_o);
  a_r2_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !rsp_valid_o);
  a_r2_nonread_data_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && !is_read |=> rsp_data_o == '0);
  a_r5_err_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> rsp_valid_o);
  a_r6_read_no_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && is_read |=> !rsp_err_o);
endmodule

// File: tb/vmac_unit_tb_top.sv
module vmac_unit_tb_top;
  localparam logic [3:0] MAC = 4'h0, MSB = 4'h1, MLD = 4'h2, MNL = 4'h3;
  localparam logic [3:0] RDL = 4'h4, RDM = 4'h5, RDH = 4'h6, WRL = 4'h8, WRH = 4'h9;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [3:0]  cmd_op_i = '0;
  logic [4:0]  cmd_sel_i = '0;
  logic [4:0]  cmd_imm_i = '0;
  logic [63:0] vs_i = '0;
  logic [63:0] vt_i = '0;
  logic        rsp_valid_o, rsp_err_o;
  logic [63:0] rsp_data_o;

  int checks = 0;
  int failures = 0;
  logic [23:0] m_acc [8];

  always #5 clk_i = ~clk_i;

  vmac_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
    .cmd_sel_i(cmd_sel_i), .cmd_imm_i(cmd_imm_i), .vs_i(vs_i), .vt_i(vt_i),
    .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o), .rsp_err_o(rsp_err_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit sel_ok(input logic [4:0] sel);
    return (sel < 5'd8) || (sel == 5'h13) || (sel == 5'h1f);
  endfunction

  function automatic bit op_bad(input logic [3:0] op, input logic [4:0] sel);
    if (op <= MNL) return !sel_ok(sel);
    return !(op inside {RDL, RDM, RDH, WRL, WRH});
  endfunction

  function automatic int opnd(input int i, input logic [4:0] sel, input logic [4:0] imm,
                              input logic [63:0] vt);
    if (sel < 5'd8) return int'($signed(vt[sel*8 +: 8]));
    if (sel == 5'h13) return int'($signed(vt[i*8 +: 8]));
    return int'(imm);
  endfunction

  function automatic logic [63:0] read_model(input logic [3:0] op);
    logic [63:0] r = '0;
    for (int i = 0; i < 8; i++)
      r[i*8 +: 8] = (op == RDH) ? m_acc[i][23:16] : (op == RDM) ? m_acc[i][15:8] : m_acc[i][7:0];
    return r;
  endfunction

  task automatic run_cmd(input logic [3:0] op, input logic [4:0] sel, input logic [4:0] imm,
                         input logic [63:0] vs, input logic [63:0] vt, input string req);
    bit          bad = op_bad(op, sel);
    logic [63:0] exp_d = (op inside {RDL, RDM, RDH}) ? read_model(op) : '0;
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_sel_i = sel; cmd_imm_i = imm; vs_i = vs; vt_i = vt;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    check({req, " R2 valid"}, 64'(rsp_valid_o), 64'd1);
    check({req, " err"}, 64'(rsp_err_o), 64'(bad));
    check({req, " data"}, rsp_data_o, exp_d);
    if (!bad) begin
      for (int i = 0; i < 8; i++) begin
        int p = int'($signed(vs[i*8 +: 8])) * opnd(i, sel, imm, vt);
        case (op)
          MAC: m_acc[i] = m_acc[i] + 24'(p);
          MSB: m_acc[i] = m_acc[i] - 24'(p);
          MLD: m_acc[i] = 24'(p);
          MNL: m_acc[i] = 24'(0 - p);
          WRH: m_acc[i] = {vs[i*8 +: 8], m_acc[i][15:0]};
          WRL: m_acc[i] = {{8{vs[i*8+7]}}, vs[i*8 +: 8], vt[i*8 +: 8]};
          default: ;
        endcase
      end
    end
  endtask

  task automatic read_all(input string req);
    run_cmd(RDH, 5'd0, 5'd0, '0, '0, req);
    run_cmd(RDM, 5'd9, 5'd0, '0, '0, req);
    run_cmd(RDL, 5'd17, 5'd0, '0, '0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [3:0] ops [11];
    void'($urandom(32'h5eed_1234));
    ops = '{MAC, MSB, MLD, MNL, RDL, RDM, RDH, WRL, WRH, 4'h7, 4'hF};
    for (int i = 0; i < 8; i++) m_acc[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check("R1 valid", 64'(rsp_valid_o), 64'd0);
    check("R1 err", 64'(rsp_err_o), 64'd0);
    check("R1 data", rsp_data_o, 64'd0);
    read_all("R1 acc");
    @(negedge clk_i);
    check("R2 idle valid", 64'(rsp_valid_o), 64'd0);
    // R3 broadcast element 3 with load
    run_cmd(MLD, 5'd3, 5'd0, 64'h80_7F_FF_01_02_FE_10_F0, 64'h11_22_33_FD_55_66_77_88, "R3 bcast R4 load");
    read_all("R3 bcast");
    // R3 full vector with accumulate
    run_cmd(MAC, 5'h13, 5'd0, 64'h80_80_7F_7F_01_FF_05_FB, 64'h80_7F_80_7F_FF_FF_09_07, "R3 full R4 acc");
    read_all("R3 full");
    // R3 immediate unsigned with subtract
    run_cmd(MSB, 5'h1f, 5'd31, 64'h80_7F_FF_01_40_C0_02_FE, '1, "R3 imm R4 sub");
    read_all("R3 imm");
    run_cmd(MNL, 5'h1f, 5'd17, 64'h80_7F_FF_01_40_C0_02_FE, '0, "R4 negload");
    read_all("R4 negload");
    // R8 / R7 then wrap
    run_cmd(WRL, 5'd30, 5'd0, 64'hFF_FF_80_7F_00_01_FF_FF, 64'hFF_00_12_34_56_78_9A_FF, "R8 write-low");
    read_all("R8");
    run_cmd(WRH, 5'd12, 5'd0, 64'h7F_7F_01_02_03_04_05_7F, '0, "R7 write-high");
    read_all("R7");
    run_cmd(MAC, 5'h1f, 5'd1, 64'h01_01_00_00_00_00_00_01, '0, "R4 wrap");
    run_cmd(RDH, 5'd0, 5'd0, '0, '0, "R4 wrap high");
    check("R4 wrap literal lane0", 64'(m_acc[0]), 64'h800000);
    read_all("R4 wrap");
    // R5 illegal selects, R9 undefined ops
    run_cmd(MAC, 5'd8, 5'd3, '1, '1, "R5 sel 8");
    run_cmd(MNL, 5'h10, 5'd3, '1, '1, "R5 sel 10");
    run_cmd(MLD, 5'h12, 5'd3, '1, '1, "R5 sel 12");
    read_all("R5 unchanged");
    run_cmd(4'h7, 5'd0, 5'd0, '1, '1, "R9 op7");
    run_cmd(4'hF, 5'h13, 5'd0, '1, '1, "R9 opF");
    run_cmd(4'hA, 5'h1f, 5'd0, '1, '1, "R9 opA");
    read_all("R9 unchanged");
    // R6 read ignores illegal select
    run_cmd(RDM, 5'h15, 5'd0, '1, '1, "R6 read bad sel");
    // random mix
    for (int n = 0; n < 600; n++) begin
      int r = $urandom % 12;
      logic [4:0] sel = (r < 8) ? 5'(r) : (r == 8) ? 5'h13 : (r == 9) ? 5'h1f : 5'($urandom);
      run_cmd(ops[$urandom % 11], sel, 5'($urandom), {$urandom, $urandom}, {$urandom, $urandom},
              "R4 R6 random");
      if ((n % 50) == 0) read_all("R6 random sweep");
    end
    read_all("R6 final");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule